// File: doc/BRIEF.md
# Serial Register-Access Slave with Address Auto-Increment

This block lets an external host read and write a bank of 16-bit registers over a four-wire serial link: an active-low select, a serial clock, a data line into the block and a data line out of it. Every transfer begins with a 16-bit command word that chooses the direction, turns address auto-increment on or off, and names one of 4096 register addresses. One or more 16-bit data words follow it.

The serial pins are oversampled by the block's own system clock, which must run at least eight times faster than the serial clock. For each completed write word the block issues a single-cycle write strobe on a parallel register-bank port. For reads, it issues a read strobe and expects the bank to return the data one system cycle later. It then loads that data into an output shifter during the longer pause that the host leaves before clocking read data.

If the host raises the select line partway through a word, the block discards the partial word and starts framing afresh on the next transfer.

Top module: `regbus_serial_slave`

## Requirements
- R1: The command word arrives MSB first, one bit per serial-clock rising edge. Bit 15 set means read and bit 15 clear means write. Bit 12 set enables auto-increment. Bits 11..0 hold the register address. Bits 14..13 are don't-care and change nothing.
- R2: When the 16th bit of a write data word is received, `reg_wr_o` goes high for exactly one system clock. At the same time `reg_addr_o` shows the target address and `reg_wdata_o` shows the received word, MSB first as sent.
- R3: When a read command word completes, `reg_rd_o` goes high for exactly one system clock with `reg_addr_o` set to the address. The value on `reg_rdata_i` in the following cycle appears on `sdo_o` MSB first. The first bit is valid before the host's first data rising edge. Each later bit changes only after a serial-clock falling edge.
- R4: With auto-increment set, any number of data words may follow within one select-low period, each going to the next address. On reads, the next register is fetched as each data word completes, so the last word is followed by one extra fetch.
- R5: The auto-increment address wraps from 0xFFF to 0x000.
- R6: With auto-increment clear, exactly one data word is handled. Further serial clocks before the select line rises cause no strobe.
- R7: If the select line rises partway through a word, no strobe is issued for that word, and the next transfer is framed from its first command bit.
- R8: `sdo_o` is held low while the select line is high.
- R9: `reg_wr_o` and `reg_rd_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n_i | input | 1 | Serial select, active low |
| sck_i | input | 1 | Serial clock from host |
| sdi_i | input | 1 | Serial data from host |
| sdo_o | output | 1 | Serial data to host |
| reg_addr_o | output | 12 | Register-bank address |
| reg_wdata_o | output | 16 | Register-bank write data |
| reg_wr_o | output | 1 | Write strobe, one cycle per word |
| reg_rd_o | output | 1 | Read strobe, one cycle per fetch |
| reg_rdata_i | input | 16 | Read data, valid the cycle after `reg_rd_o` |

## Verification
Each serial-clock edge reaches the framing logic through two synchroniser flops and an edge detector. A strobe therefore appears at the third system edge after the host's rising edge. The shifter loads one cycle after a read strobe, and each shift follows a falling edge by three system cycles. The bench does not predict absolute cycle numbers. It checks `reg_wr_o` and `reg_rd_o` at every falling system edge against ordered queues of expected address and data. It samples `sdo_o` just before each host rising edge, one half serial period after the preceding falling edge, which leaves five or more system cycles of margin. Queues are required to be empty a full serial period after the select line rises.

// File: rtl/ssl_pkg.sv
`timescale 1ns/1ps
package ssl_pkg;
   typedef enum logic [1:0] {
      PH_CMD  = 2'd0,
      PH_DATA = 2'd1,
      PH_HALT = 2'd2
   } phase_t;
endpackage

// File: rtl/ssl_sync_edge.sv
`timescale 1ns/1ps
module ssl_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n_i,
   input  logic sck_i,
   input  logic sdi_i,
   output logic cs_act_o,
   output logic rise_o,
   output logic fall_o,
   output logic sdi_o
);
   // bit 2 = select (active low), bit 1 = serial clock, bit 0 = data
   localparam logic [2:0] IDLE_PINS = 3'b100;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("ssl_sync_edge: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][2:0] stg;
   logic                   sck_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg   <= {STAGES{IDLE_PINS}};
         sck_q <= 1'b0;
      end else begin
         stg[0] <= {cs_n_i, sck_i, sdi_i};
         for (int i = 1; i < STAGES; i++) begin
            stg[i] <= stg[i-1];
         end
         sck_q <= stg[STAGES-1][1];
      end
   end

   assign cs_act_o = ~stg[STAGES-1][2];
   assign sdi_o    = stg[STAGES-1][0];
   assign rise_o   = cs_act_o &  stg[STAGES-1][1] & ~sck_q;
   assign fall_o   = cs_act_o & ~stg[STAGES-1][1] &  sck_q;
endmodule

// File: rtl/ssl_txshift.sv
`timescale 1ns/1ps
module ssl_txshift #(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_i,
   input  logic          load_i,
   input  logic [DW-1:0] din_i,
   input  logic          shift_i,
   output logic          q_o
);
   generate
      if (DW < 2) begin : g_bad_dw
         $error("ssl_txshift: DW must be at least 2");
      end
   endgenerate

   logic [DW-1:0] shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg <= '0;
      end else if (clr_i) begin
         shreg <= '0;
      end else if (load_i) begin
         shreg <= din_i;
      end else if (shift_i) begin
         shreg <= {shreg[DW-2:0], 1'b0};
      end
   end

   assign q_o = shreg[DW-1];
endmodule

// File: rtl/ssl_frame.sv
`timescale 1ns/1ps
module ssl_frame
   import ssl_pkg::*;
#(
   parameter int DW = 16,
   parameter int AW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cs_act_i,
   input  logic          rise_i,
   input  logic          fall_i,
   input  logic          sdi_i,
   output logic [AW-1:0] addr_o,
   output logic [DW-1:0] wdata_o,
   output logic          wr_o,
   output logic          rd_o,
   output logic          load_o,
   output logic          shift_o,
   output logic          rd_phase_o
);
   localparam int             CW       = $clog2(DW);
   localparam int             DIR_BIT  = DW - 1;
   localparam int             INC_BIT  = DW - 4;
   localparam logic [CW-1:0]  LAST_IDX = CW'(DW - 1);

   generate
      if (AW > INC_BIT) begin : g_bad_aw
         $error("ssl_frame: address field overlaps the control bits");
      end
      if (DW < 8) begin : g_bad_dw
         $error("ssl_frame: DW too small for a command word");
      end
   endgenerate

   phase_t        phase;
   logic [CW-1:0] cnt;
   logic [DW-1:0] sin;
   logic [DW-1:0] sin_nx;
   logic          last;
   logic          is_rd;
   logic          inc;
   logic          bump;
   logic          arm;

   assign sin_nx = {sin[DW-2:0], sdi_i};
   assign last   = (cnt == LAST_IDX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_CMD;
         cnt     <= '0;
         sin     <= '0;
         is_rd   <= 1'b0;
         inc     <= 1'b0;
         addr_o  <= '0;
         wdata_o <= '0;
         wr_o    <= 1'b0;
         rd_o    <= 1'b0;
         load_o  <= 1'b0;
         bump    <= 1'b0;
         arm     <= 1'b0;
      end else begin
         wr_o   <= 1'b0;
         rd_o   <= 1'b0;
         bump   <= 1'b0;
         load_o <= rd_o;
         if (bump) begin
            addr_o <= addr_o + AW'(1);
         end
         if (!cs_act_i) begin
            phase <= PH_CMD;
            cnt   <= '0;
            arm   <= 1'b0;
         end else begin
            if (fall_i) begin
               arm <= 1'b0;
            end
            if (rise_i && phase != PH_HALT) begin
               sin <= sin_nx;
               cnt <= last ? '0 : cnt + CW'(1);
               arm <= ~last;
               if (last) begin
                  if (phase == PH_CMD) begin
                     is_rd  <= sin_nx[DIR_BIT];
                     inc    <= sin_nx[INC_BIT];
                     addr_o <= sin_nx[AW-1:0];
                     rd_o   <= sin_nx[DIR_BIT];
                     phase  <= PH_DATA;
                  end else begin
                     if (!is_rd) begin
                        wr_o    <= 1'b1;
                        wdata_o <= sin_nx;
                        bump    <= inc;
                     end else if (inc) begin
                        addr_o <= addr_o + AW'(1);
                        rd_o   <= 1'b1;
                     end
                     if (!inc) begin
                        phase <= PH_HALT;
                     end
                  end
               end
            end
         end
      end
   end

   assign shift_o    = fall_i & arm & is_rd & (phase == PH_DATA);
   assign rd_phase_o = is_rd & (phase == PH_DATA);

   // R9
   no_rw_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_o && rd_o));
   // R2
   wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_o |=> !wr_o);
   // R3
   rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_o |=> !rd_o);
   // R7
   abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(cs_act_i) |-> (!wr_o && !rd_o));
endmodule

// File: rtl/regbus_serial_slave.sv
`timescale 1ns/1ps
module regbus_serial_slave #(
   parameter int DW          = 16,
   parameter int AW          = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cs_n_i,
   input  logic          sck_i,
   input  logic          sdi_i,
   output logic          sdo_o,
   output logic [AW-1:0] reg_addr_o,
   output logic [DW-1:0] reg_wdata_o,
   output logic          reg_wr_o,
   output logic          reg_rd_o,
   input  logic [DW-1:0] reg_rdata_i
);
   logic cs_act, rise, fall, sdi_s;
   logic load, shift, rd_phase, tx_q;

   ssl_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_n_i   (cs_n_i),
      .sck_i    (sck_i),
      .sdi_i    (sdi_i),
      .cs_act_o (cs_act),
      .rise_o   (rise),
      .fall_o   (fall),
      .sdi_o    (sdi_s)
   );

   ssl_frame #(.DW(DW), .AW(AW)) u_frame (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_act_i   (cs_act),
      .rise_i     (rise),
      .fall_i     (fall),
      .sdi_i      (sdi_s),
      .addr_o     (reg_addr_o),
      .wdata_o    (reg_wdata_o),
      .wr_o       (reg_wr_o),
      .rd_o       (reg_rd_o),
      .load_o     (load),
      .shift_o    (shift),
      .rd_phase_o (rd_phase)
   );

   ssl_txshift #(.DW(DW)) u_tx (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (~cs_act),
      .load_i  (load),
      .din_i   (reg_rdata_i),
      .shift_i (shift),
      .q_o     (tx_q)
   );

   assign sdo_o = cs_act & rd_phase & tx_q;
endmodule

// File: tb/tb_regbus_serial_slave.sv
`timescale 1ns/1ps
module tb_regbus_serial_slave;
   localparam int HALF = 64;
   localparam int GAP  = 160;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1;
   logic        sck = 1'b0;
   logic        sdi = 1'b0;
   logic [15:0] rdata = '0;
   logic        sdo;
   logic [11:0] addr;
   logic [15:0] wdata;
   logic        wr;
   logic        rd;

   always #4 clk = ~clk;

   regbus_serial_slave dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .cs_n_i      (cs_n),
      .sck_i       (sck),
      .sdi_i       (sdi),
      .sdo_o       (sdo),
      .reg_addr_o  (addr),
      .reg_wdata_o (wdata),
      .reg_wr_o    (wr),
      .reg_rd_o    (rd),
      .reg_rdata_i (rdata)
   );

   int total = 0;
   int bad   = 0;
   bit finished = 0;
   int cs_hi_cnt = 0;

   logic [15:0] bank  [bit [11:0]];
   logic [15:0] model [bit [11:0]];
   logic [27:0] exp_wr [$];
   logic [11:0] exp_rd [$];

   function automatic logic [15:0] dflt(input logic [11:0] a);
      return {4'h5, a} ^ 16'h3C00;
   endfunction

   function automatic logic [15:0] model_val(input logic [11:0] a);
      if (model.exists(a)) return model[a];
      return dflt(a);
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // register bank seen by the block: returns data one cycle after a fetch
   always @(posedge clk) begin
      if (rd) rdata <= bank.exists(addr) ? bank[addr] : dflt(addr);
      if (wr) bank[addr] = wdata;
   end

   // per-clock comparison against the expected strobe streams
   always @(negedge clk) begin
      if (rst_n) begin
         if (wr && rd) check(1'b0, "R9", "strobe overlap", {wr, rd}, 0);
         if (wr) begin
            if (exp_wr.size() == 0) check(1'b0, "R6/R7", "unexpected write", {4'h0, addr, wdata}, 0);
            else begin
               logic [27:0] e;
               e = exp_wr.pop_front();
               check({addr, wdata} == e, "R2", "write addr/data", {4'h0, addr, wdata}, {4'h0, e});
            end
         end
         if (rd) begin
            if (exp_rd.size() == 0) check(1'b0, "R6/R7", "unexpected read", {20'h0, addr}, 0);
            else begin
               logic [11:0] e;
               e = exp_rd.pop_front();
               check(addr == e, "R3", "read addr", {20'h0, addr}, {20'h0, e});
            end
         end
         if (cs_n) cs_hi_cnt++;
         else cs_hi_cnt = 0;
         if (cs_hi_cnt >= 4) check(sdo == 1'b0, "R8", "sdo idle", {31'h0, sdo}, 0);
      end
   end

   task automatic bitx(input logic b, output logic so);
      sdi = b;
      #(HALF);
      so = sdo;
      sck = 1'b1;
      #(HALF);
      sck = 1'b0;
   endtask

   task automatic word_io(input logic [15:0] w, output logic [15:0] got);
      logic b;
      for (int i = 15; i >= 0; i--) begin
         bitx(w[i], b);
         got[i] = b;
      end
   endtask

   task automatic finish_xfer();
      #(HALF);
      cs_n = 1'b1;
      #(HALF * 2);
      check(exp_wr.size() == 0, "R2", "writes outstanding", exp_wr.size(), 0);
      check(exp_rd.size() == 0, "R3", "reads outstanding", exp_rd.size(), 0);
   endtask

   task automatic xfer(input bit is_read, input bit inc, input logic [1:0] rsv,
                       input logic [11:0] a, input int n, input logic [15:0] seed,
                       input int extra, input string tag);
      logic [15:0] cmd, got, d, e;
      logic [11:0] aa;
      logic        b;
      cmd = {is_read, rsv, inc, a};
      if (!is_read) begin
         for (int i = 0; i < n; i++) begin
            aa = a + 12'(i);
            d  = seed ^ 16'(i * 16'h0123);
            exp_wr.push_back({aa, d});
            model[aa] = d;
         end
      end else begin
         for (int i = 0; i < n; i++) exp_rd.push_back(a + 12'(i));
         if (inc) exp_rd.push_back(a + 12'(n));
      end
      cs_n = 1'b0;
      #(16);
      word_io(cmd, got);
      if (is_read) #(GAP);
      for (int i = 0; i < n; i++) begin
         aa = a + 12'(i);
         d  = seed ^ 16'(i * 16'h0123);
         word_io(is_read ? 16'h0000 : d, got);
         if (is_read) begin
            e = model_val(aa);
            check(got == e, tag, "read word", {16'h0, got}, {16'h0, e});
            #(GAP);
         end
      end
      for (int i = 0; i < extra; i++) bitx(1'b1, b);
      finish_xfer();
   endtask

   task automatic aborted(input logic [31:0] bits, input int nbits);
      logic b;
      cs_n = 1'b0;
      #(16);
      for (int i = 31; i > 31 - nbits; i--) bitx(bits[i], b);
      finish_xfer();
   endtask

   initial begin
      #(1_000_000);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL R9 watchdog actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (10) @(posedge clk);
      #3;
      check(sdo == 1'b0, "R8", "reset sdo", {31'h0, sdo}, 0);
      check(wr == 1'b0, "R2", "reset write strobe", {31'h0, wr}, 0);
      check(rd == 1'b0, "R3", "reset read strobe", {31'h0, rd}, 0);
      rst_n = 1'b1;
      repeat (4) @(posedge clk);
      #3;
      // R1 R2: single write then read back
      xfer(1'b0, 1'b0, 2'b00, 12'h123, 1, 16'hA5C3, 0, "R2");
      xfer(1'b1, 1'b0, 2'b00, 12'h123, 1, 16'h0000, 0, "R3");
      // R4: burst write and burst read
      xfer(1'b0, 1'b1, 2'b00, 12'h200, 4, 16'h1E0F, 0, "R4");
      xfer(1'b1, 1'b1, 2'b00, 12'h200, 4, 16'h0000, 0, "R4");
      // R5: wrap past the top address
      xfer(1'b0, 1'b1, 2'b00, 12'hFFE, 3, 16'hC0DE, 0, "R5");
      xfer(1'b1, 1'b1, 2'b00, 12'hFFF, 2, 16'h0000, 0, "R5");
      // R1: reserved bits set change nothing
      xfer(1'b0, 1'b0, 2'b11, 12'h050, 1, 16'h7E81, 0, "R1");
      xfer(1'b1, 1'b0, 2'b11, 12'h050, 1, 16'h0000, 0, "R1");
      // R6: extra clocks after a non-incrementing word are ignored
      xfer(1'b0, 1'b0, 2'b00, 12'h060, 1, 16'h4242, 16, "R6");
      xfer(1'b1, 1'b0, 2'b00, 12'h061, 1, 16'h0000, 0, "R6");
      xfer(1'b1, 1'b0, 2'b00, 12'h060, 1, 16'h0000, 20, "R6");
      // R7: abort inside a command word, then inside a write data word
      aborted({16'h0070, 16'h0000}, 9);
      aborted({16'h0070, 16'hFFFF}, 23);
      xfer(1'b1, 1'b0, 2'b00, 12'h070, 1, 16'h0000, 0, "R7");
      xfer(1'b0, 1'b0, 2'b00, 12'h071, 1, 16'h9009, 0, "R7");
      xfer(1'b1, 1'b0, 2'b00, 12'h071, 1, 16'h0000, 0, "R7");
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule